// File: doc/BRIEF.md
# Flag-Conditioned Relative Jump Unit

This block runs the jump class of a CPU with 16-bit instruction words and a 32-bit byte-addressed program counter. A fetch stage hands it the two words of a jump instruction, one per valid cycle. With the first word it also supplies the address of that word, the stack pointer and the four ALU flags (carry, overflow, negative, zero). The unit checks the 4-bit condition field against those flags. It then reports whether the jump is taken and which PC execution continues from. The flags are only read and are never changed.

A taken jump lands at the address that follows the second word plus a sign-extended 24-bit byte offset. The top byte of the offset is in the first word and the low sixteen bits are the whole second word. A not-taken jump, or one with an unlisted condition code, falls through to the address after the second word. The call form first stores that return address at the stack pointer as two 16-bit writes, stalling on memory ready. The new PC is published only after both writes complete.

Top module: `jmp_unit`

## Requirements
- R1: After a synchronous active-low reset, `done` and `mem_we` are 0 and `iw_ready` is 1. A word already taken before reset does not combine with words taken after it.
- R2: A first word whose bits 15..12 are not 0001 is dropped without producing `done`. The next word offered is treated as a new first word.
- R3: Condition field (first word bits 11..8) 0000 always jumps: `pc_out` = address of first word + 4 + sign-extended offset. The offset is {first word bits 7..0, second word bits 15..0}.
- R4: Codes 0001, 0010, 0100 and 1000 jump when zero, negative, overflow or carry respectively is 1.
- R5: Codes 1110, 1101, 1011 and 0111 jump when zero, negative, overflow or carry respectively is 0.
- R6: A jump whose condition fails reports `taken` = 0 and `pc_out` = address of first word + 4.
- R7: The offset is a signed byte displacement. Negative offsets move backwards, and the sum wraps modulo 2^32.
- R8: Code 1111 (call) holds `mem_we` high with address = SP and data = return address bits 31..16, then address = SP+2 and data = return address bits 15..0. Each write advances only on `mem_ready`, address and data stay stable while stalled, and `iw_ready` is 0 during the writes.
- R9: A call raises `done` with `taken` = 1 and `pc_out` = target in the cycle after the second write is accepted, and not before.
- R10: Any other condition code is not taken, falls through as in R6 and raises `illegal` in the `done` cycle.
- R11: `done` is a one-cycle pulse. For non-call jumps it appears in the cycle after the second word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iw_valid | input | 1 | Instruction word valid |
| iw_data | input | 16 | Instruction word |
| iw_ready | output | 1 | Unit can accept a word |
| pc_in | input | 32 | Byte address of the first word, sampled with it |
| sp_in | input | 32 | Stack pointer, sampled with the first word |
| flag_c | input | 1 | ALU carry flag, sampled with the first word |
| flag_o | input | 1 | ALU overflow flag, sampled with the first word |
| flag_n | input | 1 | ALU negative flag, sampled with the first word |
| flag_z | input | 1 | ALU zero flag, sampled with the first word |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ready | input | 1 | Memory accepts the current write |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Jump taken, valid with `done` |
| illegal | output | 1 | Unlisted condition code, valid with `done` |
| pc_out | output | 32 | Next PC, valid with `done` |

## Verification
The assertions assume that `mem_ready` is a plain level from memory, that the flags, `pc_in` and `sp_in` are meaningful in the cycle the first word is accepted, and that words are offered only while `iw_ready` is high. The bench changes every input half a cycle away from the clock edge. It sets the flags, PC and SP before offering the first word and keeps them steady until `done`. It offers words only in the idle or second-word state. During a call it stalls memory for several cycles before raising ready, so the hold behaviour is exercised under the same conditions the assertions take for granted.

// File: rtl/jmp_pkg.sv
// Package: shared constants and state type for the jump unit.
// Assumes 16-bit instruction words with opcode in the top nibble.
package jmp_pkg;
    localparam logic [3:0] OPC_JUMP    = 4'b0001;
    localparam logic [3:0] COND_ALWAYS = 4'b0000;
    localparam logic [3:0] COND_CALL   = 4'b1111;

    // Flag vector bit positions, shared by unit and condition evaluator
    localparam int FL_Z = 0;
    localparam int FL_N = 1;
    localparam int FL_O = 2;
    localparam int FL_C = 3;

    typedef enum logic [1:0] {
        ST_WORD1,
        ST_WORD2,
        ST_SAVE_HI,
        ST_SAVE_LO
    } jstate_t;
endpackage

// File: rtl/jmp_cond_eval.sv
// Condition evaluator: a one-hot code tests its flag for 1 and the bitwise
// complement of that code tests the same flag for 0. Code 0 always jumps,
// code all-ones is a call (taken). Anything else is flagged illegal.
// Assumes flag bit i pairs with one-hot code bit i.
module jmp_cond_eval
    import jmp_pkg::*;
#(
    parameter int NF = 4
) (
    input  logic [NF-1:0] cond,
    input  logic [NF-1:0] flags,
    output logic          take,
    output logic          is_call,
    output logic          illegal
);
    logic [NF-1:0] set_hit, clr_hit, set_known, clr_known;

    // One comparator pair per flag
    for (genvar i = 0; i < NF; i++) begin : g_flag
        localparam logic [NF-1:0] SEL = NF'(1) << i;
        assign set_known[i] = (cond == SEL);
        assign clr_known[i] = (cond == ~SEL);
        assign set_hit[i]   = set_known[i] &  flags[i];
        assign clr_hit[i]   = clr_known[i] & ~flags[i];
    end

    logic always_jmp;

    // Combine per-flag results into the decision outputs
    always_comb begin
        always_jmp = (cond == NF'(COND_ALWAYS));
        is_call    = (cond == NF'(COND_CALL));
        take       = always_jmp | is_call | (|set_hit) | (|clr_hit);
        illegal    = ~(always_jmp | is_call | (|set_known) | (|clr_known));
    end

    // R10: an illegal code is never taken, and a call is never illegal
    always_comb begin
        if (!$isunknown(cond)) begin
            a_r10_illegal_excl: assert (!(illegal && (take || is_call)));
        end
    end
endmodule

// File: rtl/jmp_target_add.sv
// Target adder: forms the fall-through address (after both words) and the
// PC-relative target by adding the sign-extended offset to it.
// Assumes two instruction words per jump, WB bytes each.
module jmp_target_add #(
    parameter int AW = 32,
    parameter int OW = 24,
    parameter int WB = 2
) (
    input  logic [AW-1:0] first_pc,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] next_pc,
    output logic [AW-1:0] target
);
    localparam logic [AW-1:0] STEP = AW'(2 * WB);

    // Sign extend and add
    always_comb begin
        next_pc = first_pc + STEP;
        target  = next_pc + {{(AW-OW){offset[OW-1]}}, offset};
    end
endmodule

// File: rtl/jmp_unit.sv
// Jump unit top: accepts the two words of a jump, evaluates its condition
// on flags sampled with the first word, stores the return address for a
// call (high half at SP, low half at SP+2) and pulses done with the next PC.
// Assumes words are offered only while iw_ready is high and AW = 2*WW.
module jmp_unit
    import jmp_pkg::*;
#(
    parameter int AW = 32,
    parameter int WW = 16,
    parameter int OW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iw_valid,
    input  logic [WW-1:0] iw_data,
    output logic          iw_ready,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic          flag_c,
    input  logic          flag_o,
    input  logic          flag_n,
    input  logic          flag_z,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    input  logic          mem_ready,
    output logic          done,
    output logic          taken,
    output logic          illegal,
    output logic [AW-1:0] pc_out
);
    localparam int HOW = OW - WW;   // offset bits carried in word 1
    localparam int WB  = WW / 8;    // bytes per word
    localparam int NF  = 4;

    jstate_t        st;
    logic [NF-1:0]  cond_q, flg_q;
    logic [HOW-1:0] hoff_q;
    logic [AW-1:0]  pc_q, sp_q, ret_q, tgt_q, pcout_q;
    logic           done_q, taken_q, ill_q;

    logic           c_take, c_call, c_ill;
    logic [AW-1:0]  a_next, a_tgt;
    logic [NF-1:0]  flg_now;

    // Pack live flags in package bit order
    always_comb begin
        flg_now       = '0;
        flg_now[FL_Z] = flag_z;
        flg_now[FL_N] = flag_n;
        flg_now[FL_O] = flag_o;
        flg_now[FL_C] = flag_c;
    end

    jmp_cond_eval #(.NF(NF)) u_cond (
        .cond    (cond_q),
        .flags   (flg_q),
        .take    (c_take),
        .is_call (c_call),
        .illegal (c_ill)
    );

    jmp_target_add #(.AW(AW), .OW(OW), .WB(WB)) u_add (
        .first_pc (pc_q),
        .offset   ({hoff_q, iw_data}),
        .next_pc  (a_next),
        .target   (a_tgt)
    );

    // Sequencer: word capture, decision, return-address store, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_WORD1;
            cond_q  <= '0;
            flg_q   <= '0;
            hoff_q  <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
            ret_q   <= '0;
            tgt_q   <= '0;
            pcout_q <= '0;
            done_q  <= 1'b0;
            taken_q <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            taken_q <= 1'b0;
            ill_q   <= 1'b0;
            unique case (st)
                ST_WORD1: begin
                    if (iw_valid && iw_data[WW-1 -: 4] == OPC_JUMP) begin
                        cond_q <= iw_data[WW-5 -: NF];
                        hoff_q <= iw_data[HOW-1:0];
                        flg_q  <= flg_now;
                        pc_q   <= pc_in;
                        sp_q   <= sp_in;
                        st     <= ST_WORD2;
                    end
                end
                ST_WORD2: begin
                    if (iw_valid) begin
                        ret_q <= a_next;
                        tgt_q <= a_tgt;
                        if (c_call) begin
                            st <= ST_SAVE_HI;
                        end else begin
                            done_q  <= 1'b1;
                            taken_q <= c_take;
                            ill_q   <= c_ill;
                            pcout_q <= c_take ? a_tgt : a_next;
                            st      <= ST_WORD1;
                        end
                    end
                end
                ST_SAVE_HI: begin
                    if (mem_ready) st <= ST_SAVE_LO;
                end
                ST_SAVE_LO: begin
                    if (mem_ready) begin
                        done_q  <= 1'b1;
                        taken_q <= 1'b1;
                        pcout_q <= tgt_q;
                        st      <= ST_WORD1;
                    end
                end
                default: st <= ST_WORD1;
            endcase
        end
    end

    // Drive memory and handshake outputs from state
    always_comb begin
        iw_ready  = (st == ST_WORD1) || (st == ST_WORD2);
        mem_we    = (st == ST_SAVE_HI) || (st == ST_SAVE_LO);
        mem_addr  = (st == ST_SAVE_LO) ? sp_q + AW'(WB) : sp_q;
        mem_wdata = (st == ST_SAVE_LO) ? ret_q[WW-1:0] : ret_q[AW-1 -: WW];
        done      = done_q;
        taken     = taken_q;
        illegal   = ill_q;
        pc_out    = pcout_q;
    end

    // R8: a stalled write keeps its request, address and data
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !mem_ready |=> mem_we && $stable(mem_addr) && $stable(mem_wdata));

    // R8: no instruction word is accepted while storing
    a_r8_no_fetch_in_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !iw_ready);

    // R9: a call completes exactly when its store ends
    a_r9_done_ends_store: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> done && taken);

    // R11: done lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: illegal appears only with done and never with taken
    a_r10_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && !taken);
endmodule

// File: tb/sim_jmp_unit.sv
// Bench for jmp_unit: vector table of non-call jumps, then directed tests
// for reset, non-jump words and calls with and without memory stalls.
module sim_jmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iw_valid = 1'b0;
    logic [15:0] iw_data = '0;
    logic        iw_ready;
    logic [31:0] pc_in = '0, sp_in = '0;
    logic [3:0]  fl = '0;   // {c, o, n, z}
    logic        mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        done, taken, illegal;
    logic [31:0] pc_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    jmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .iw_valid(iw_valid), .iw_data(iw_data),
        .iw_ready(iw_ready), .pc_in(pc_in), .sp_in(sp_in),
        .flag_c(fl[3]), .flag_o(fl[2]), .flag_n(fl[1]), .flag_z(fl[0]),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .done(done), .taken(taken),
        .illegal(illegal), .pc_out(pc_out)
    );

    // Vector fields: {word1, word2, flags c/o/n/z, first-word PC}
    localparam int NV = 15;
    localparam logic [67:0] VEC [NV] = '{
        {16'h1000, 16'h0010, 4'b0000, 32'h0000_1000},
        {16'h1100, 16'h0100, 4'b0001, 32'h0000_2000},
        {16'h1100, 16'h0100, 4'b1110, 32'h0000_2000},
        {16'h1200, 16'h0040, 4'b0010, 32'h0001_0000},
        {16'h1400, 16'h0020, 4'b0100, 32'h0000_3000},
        {16'h1800, 16'h0020, 4'b0111, 32'h0000_3000},
        {16'h1E00, 16'h0030, 4'b0001, 32'h0000_4000},
        {16'h1E00, 16'h0030, 4'b1110, 32'h0000_4000},
        {16'h1D00, 16'h0008, 4'b1101, 32'h0000_5000},
        {16'h1B00, 16'h0008, 4'b0100, 32'h0000_5000},
        {16'h1700, 16'h0008, 4'b0111, 32'h0000_6000},
        {16'h10FF, 16'hFFFC, 4'b0000, 32'h0000_2000},
        {16'h1080, 16'h0000, 4'b0000, 32'h0000_0010},
        {16'h137F, 16'hFFFF, 4'b1111, 32'h0000_7000},
        {16'h1C12, 16'h3456, 4'b0000, 32'h0000_8000}
    };

    function automatic bit ref_taken(input logic [3:0] c, input logic [3:0] f);
        case (c)
            4'h0: return 1'b1;
            4'h1: return f[0];
            4'h2: return f[1];
            4'h4: return f[2];
            4'h8: return f[3];
            4'hE: return !f[0];
            4'hD: return !f[1];
            4'hB: return !f[2];
            4'h7: return !f[3];
            4'hF: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit ref_illegal(input logic [3:0] c);
        case (c)
            4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'hE, 4'hD, 4'hB, 4'h7, 4'hF: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h0: return "R3";
            4'h1, 4'h2, 4'h4, 4'h8: return "R4";
            4'hE, 4'hD, 4'hB, 4'h7: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Offer one word for a single cycle; returns at the negedge after acceptance
    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        iw_valid = 1'b1;
        iw_data  = w;
        @(negedge clk);
        iw_valid = 1'b0;
    endtask

    task automatic run_jump(input logic [15:0] w1, input logic [15:0] w2,
                            input logic [3:0] f, input logic [31:0] pc);
        logic [31:0] nxt, tgt;
        bit tk;
        nxt = pc + 32'd4;
        tgt = nxt + {{8{w1[7]}}, w1[7:0], w2};
        tk  = ref_taken(w1[11:8], f);
        fl = f;
        pc_in = pc;
        send_word(w1);
        send_word(w2);
        check({req_of(w1[11:8]), " done"}, {31'd0, done}, 32'd1);
        check({req_of(w1[11:8]), " taken"}, {31'd0, taken}, {31'd0, tk});
        check(tk ? (w1[7] ? "R7 target" : "R3 target") : "R6 fallthrough", pc_out, tk ? tgt : nxt);
        check("R10 illegal flag", {31'd0, illegal}, {31'd0, ref_illegal(w1[11:8])});
        @(negedge clk);
        check("R11 pulse width", {31'd0, done}, 32'd0);
    endtask

    task automatic run_call(input logic [15:0] w2, input logic [31:0] pc,
                            input logic [31:0] sp, input int stall);
        logic [31:0] ret, tgt;
        ret = pc + 32'd4;
        tgt = ret + {{8{1'b0}}, 8'h00, w2};
        pc_in = pc;
        sp_in = sp;
        mem_ready = (stall == 0);
        send_word(16'h1F00);
        send_word(w2);
        check("R8 we high", {31'd0, mem_we}, 32'd1);
        check("R8 addr hi", mem_addr, sp);
        check("R8 data hi", {16'd0, mem_wdata}, {16'd0, ret[31:16]});
        check("R8 no fetch", {31'd0, iw_ready}, 32'd0);
        check("R9 no early done", {31'd0, done}, 32'd0);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check("R8 stall addr", mem_addr, sp);
            check("R8 stall data", {16'd0, mem_wdata}, {16'd0, ret[31:16]});
            check("R9 no done in stall", {31'd0, done}, 32'd0);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        check("R8 addr lo", mem_addr, sp + 32'd2);
        check("R8 data lo", {16'd0, mem_wdata}, {16'd0, ret[15:0]});
        check("R9 no done before lo", {31'd0, done}, 32'd0);
        @(negedge clk);
        mem_ready = 1'b0;
        check("R9 done", {31'd0, done}, 32'd1);
        check("R9 taken", {31'd0, taken}, 32'd1);
        check("R9 target", pc_out, tgt);
        check("R9 store ended", {31'd0, mem_we}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 we after reset", {31'd0, mem_we}, 32'd0);
        check("R1 ready after reset", {31'd0, iw_ready}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            run_jump(VEC[i][67:52], VEC[i][51:36], VEC[i][35:32], VEC[i][31:0]);
        end

        // R2: non-jump first word ignored, then a normal jump decodes cleanly
        send_word(16'h2345);
        check("R2 no done", {31'd0, done}, 32'd0);
        send_word(16'h0000);
        check("R2 no done second", {31'd0, done}, 32'd0);
        run_jump(16'h1000, 16'h0100, 4'b0000, 32'h0000_9000);

        // R1: reset mid-instruction discards the first word
        fl = 4'b0000;
        send_word(16'h1000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        send_word(16'h1000);
        check("R1 no done after reset", {31'd0, done}, 32'd0);
        send_word(16'h0020);
        check("R1 clean restart", {31'd0, done}, 32'd1);

        // Calls: with a memory stall and without
        run_call(16'h0200, 32'h0001_2340, 32'h8000_0000, 3);
        @(negedge clk);
        check("R11 after call", {31'd0, done}, 32'd0);
        run_call(16'h7FFE, 32'hABCD_0000, 32'h0000_F000, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule